// File: doc/BRIEF.md
# Comma-Detecting Serial Word Aligner

This block turns a serial bit stream, one bit per clock, into 10-bit transmission characters. Each character leaves the block with a one-cycle valid strobe. A slot flag alternates from one character to the next, so two characters make up a 20-bit half-word: slot flag 0 marks the first slot and 1 marks the second.

While alignment is enabled, the block tests every bit position of the stream for the 7-bit synchronisation mark. If the mark is found off the character boundary, straddling two characters, or on the boundary but in the first slot, the block restarts its bit count and its slot. The character that carries the mark then leaves correctly framed in the second slot. Every character that carries the mark properly framed is tagged with a one-cycle detect flag.

While alignment is disabled, the framing and the slot cadence set at reset or at the last realignment are held, whatever the data. Clock recovery, the serial front end and line decoding belong to the surrounding logic.

Top module: `serial_word_aligner`

## Requirements
- R1: A synchronous active-high reset clears the bit count and the slot. From the first cycle after reset, `char_vld`, `comma_flag` and `half_sel` are all low.
- R2: With `align_en` low, `char_vld` pulses once every 10 bits, on the 10th, 20th, ... bit after reset or after the last realignment. `half_sel` alternates 0, 1, 0, ... starting at 0 after reset. A mark at any other offset does not move this cadence.
- R3: `char_data[0]` holds the earliest received bit of the character and `char_data[9]` the latest.
- R4: The mark is seven bits that, earliest first, read 0011111. With `BOTH_POL` set (the default), its complement 1100000 also counts. Properly framed, it sits in `char_data[6:0]` as 7'b1111100, or as 7'b0000011 for the complement.
- R5: With `align_en` high, a mark at any other bit offset, including one that straddles two characters, makes the block reframe. The character that holds the mark is then output whole, with `comma_flag` high and `half_sel` high.
- R6: With `align_en` high, a properly framed mark that falls in the first slot (`half_sel` would be 0) forces a slot change. The mark character is output with `half_sel` 1.
- R7: With `align_en` high, a mark that is already properly framed in the second slot changes nothing. Characters keep their 10-bit cadence and slot alternation across it.
- R8: `comma_flag` is high for exactly the one `char_vld` cycle of each character that carries a properly framed mark, whatever the state of `align_en`. It is never high without `char_vld`.
- R9: Every character after the mark character is output intact, every 10 bits, with `half_sel` alternating 0, 1, ... after the mark character.
- R10: A character appears on the outputs in the cycle after the clock edge that samples its tenth bit.
- R11: `char_vld` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_bit | input | 1 | Serial data bit, one per clock |
| align_en | input | 1 | High: realign on marks; low: hold the current framing |
| char_vld | output | 1 | One-cycle strobe for a completed character |
| char_data | output | CHAR_W | Character, bit 0 received first |
| half_sel | output | 1 | Slot of the character within the half-word (0 first, 1 second) |
| comma_flag | output | 1 | High with a character that carries a framed mark |

## Verification
Every output register is loaded from the edge that samples a character's tenth bit. A character is therefore due exactly one clock after that bit is presented, and each following character lands 10 bits later. The bench drives a bit on each falling edge and, on the next falling edge, reads the response to the bit it drove before. Each expected character is filed under the stream index of its tenth bit, so the mark character and each following payload word are matched against the exact cycle they are due in. When alignment is off, the strobe is also checked bit by bit against the fixed 10-bit cadence.

// File: rtl/swa_pkg.sv
package swa_pkg;
   typedef enum logic {
      SLOT_FIRST  = 1'b0,
      SLOT_SECOND = 1'b1
   } slot_e;
endpackage

// File: rtl/swa_shift.sv
module swa_shift #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ser_bit,
   output logic [W-1:0] win
);
   logic [W-2:0] hist_q;

   // Newest bit enters at the top; the oldest of the last W sits at bit 0.
   assign win = {ser_bit, hist_q};

   always_ff @(posedge clk) begin
      if (rst) hist_q <= '0;
      else     hist_q <= win[W-1:1];
   end
endmodule

// File: rtl/swa_match.sv
module swa_match #(
   parameter int          MARK_W   = 7,
   parameter logic [6:0]  MARK_PAT = 7'b1111100,
   parameter bit          BOTH_POL = 1'b1
) (
   input  logic [MARK_W-1:0] tail,
   output logic              hit
);
   logic hit_pos;
   assign hit_pos = (tail == MARK_PAT[MARK_W-1:0]);

   generate
      if (BOTH_POL) begin : g_both
         logic hit_neg;
         assign hit_neg = (tail == ~MARK_PAT[MARK_W-1:0]);
         assign hit = hit_pos | hit_neg;
      end else begin : g_single
         assign hit = hit_pos;
      end
   endgenerate
endmodule

// File: rtl/swa_ctrl.sv
module swa_ctrl
   import swa_pkg::*;
#(
   parameter int CHAR_W = 10,
   parameter int MARK_W = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              align_en,
   input  logic              hit,
   input  logic [CHAR_W-1:0] win,
   output logic              char_vld,
   output logic [CHAR_W-1:0] char_data,
   output logic              half_sel,
   output logic              comma_flag
);
   localparam int CW = $clog2(CHAR_W);
   localparam logic [CW-1:0] LAST_POS = CW'(CHAR_W - 1);
   localparam logic [CW-1:0] MARK_END = CW'(MARK_W - 1);
   localparam logic [CW-1:0] MARK_RST = CW'(MARK_W);

   logic [CW-1:0] cnt_q;
   slot_e         slot_q;
   logic          pend_q;
   logic          framed, realign;

   // The bit arriving now is bit number cnt_q of the character.
   assign framed  = hit && (cnt_q == MARK_END);
   assign realign = align_en && hit && !(framed && slot_q == SLOT_SECOND);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q      <= '0;
         slot_q     <= SLOT_FIRST;
         pend_q     <= 1'b0;
         char_vld   <= 1'b0;
         char_data  <= '0;
         half_sel   <= 1'b0;
         comma_flag <= 1'b0;
      end else begin
         char_vld   <= 1'b0;
         comma_flag <= 1'b0;
         if (realign) begin
            cnt_q  <= MARK_RST;
            slot_q <= SLOT_SECOND;
            pend_q <= 1'b1;
         end else if (cnt_q == LAST_POS) begin
            char_vld   <= 1'b1;
            char_data  <= win;
            half_sel   <= slot_q;
            comma_flag <= pend_q;
            slot_q     <= (slot_q == SLOT_FIRST) ? SLOT_SECOND : SLOT_FIRST;
            pend_q     <= 1'b0;
            cnt_q      <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            if (framed) pend_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/serial_word_aligner.sv
module serial_word_aligner #(
   parameter int         CHAR_W   = 10,
   parameter int         MARK_W   = 7,
   parameter logic [6:0] MARK_PAT = 7'b1111100,
   parameter bit         BOTH_POL = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ser_bit,
   input  logic              align_en,
   output logic              char_vld,
   output logic [CHAR_W-1:0] char_data,
   output logic              half_sel,
   output logic              comma_flag
);
   generate
      if (MARK_W >= CHAR_W || MARK_W < 2 || MARK_W > 7) begin : g_bad_mark
         $error("serial_word_aligner: MARK_W must lie in 2..7 and be below CHAR_W");
      end
   endgenerate

   logic [CHAR_W-1:0] win;
   logic              hit;

   swa_shift #(.W(CHAR_W)) shift_i (
      .clk(clk), .rst(rst), .ser_bit(ser_bit), .win(win)
   );

   swa_match #(.MARK_W(MARK_W), .MARK_PAT(MARK_PAT), .BOTH_POL(BOTH_POL)) match_i (
      .tail(win[CHAR_W-1 -: MARK_W]), .hit(hit)
   );

   swa_ctrl #(.CHAR_W(CHAR_W), .MARK_W(MARK_W)) ctrl_i (
      .clk(clk), .rst(rst), .align_en(align_en), .hit(hit), .win(win),
      .char_vld(char_vld), .char_data(char_data),
      .half_sel(half_sel), .comma_flag(comma_flag)
   );
endmodule

// File: rtl/swa_chk.sv
module swa_chk #(
   parameter int         CHAR_W   = 10,
   parameter int         MARK_W   = 7,
   parameter logic [6:0] MARK_PAT = 7'b1111100,
   parameter bit         BOTH_POL = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              char_vld,
   input logic [CHAR_W-1:0] char_data,
   input logic              half_sel,
   input logic              comma_flag
);
   logic seen_q, last_half_q;
   logic mark_ok;

   assign mark_ok = (char_data[MARK_W-1:0] == MARK_PAT[MARK_W-1:0]) ||
                    (BOTH_POL && char_data[MARK_W-1:0] == ~MARK_PAT[MARK_W-1:0]);

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_q      <= 1'b0;
         last_half_q <= 1'b0;
      end else if (char_vld) begin
         seen_q      <= 1'b1;
         last_half_q <= half_sel;
      end
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> (!char_vld && !comma_flag && !half_sel));

   // R8
   flag_needs_vld_chk: assert property (@(posedge clk) disable iff (rst)
      comma_flag |-> char_vld);

   // R4
   flag_mark_framed_chk: assert property (@(posedge clk) disable iff (rst)
      comma_flag |-> mark_ok);

   // R11
   no_double_vld_chk: assert property (@(posedge clk) disable iff (rst)
      char_vld |=> !char_vld);

   // R9
   slot_toggle_chk: assert property (@(posedge clk) disable iff (rst)
      (char_vld && !comma_flag && seen_q) |-> (half_sel != last_half_q));
endmodule

bind serial_word_aligner swa_chk #(
   .CHAR_W(CHAR_W), .MARK_W(MARK_W), .MARK_PAT(MARK_PAT), .BOTH_POL(BOTH_POL)
) chk_i (
   .clk(clk), .rst(rst), .char_vld(char_vld), .char_data(char_data),
   .half_sel(half_sel), .comma_flag(comma_flag)
);

// File: tb/serial_word_aligner_tb.sv
`timescale 1ns/1ps
module serial_word_aligner_tb_top;
   localparam int          CW    = 10;
   localparam logic [9:0]  K_NEG = 10'h17C;
   localparam logic [9:0]  K_POS = 10'h283;
   localparam int          NV    = 12;
   // {align_en, polarity (1 = complement form), lead bits[5:0]}
   localparam logic [7:0] VECS [NV] = '{
      8'h80, 8'hC3, 8'h87, 8'hCA, 8'h8D, 8'hD4,
      8'h9F, 8'hE7, 8'h0A, 8'h54, 8'h04, 8'h51
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ser_bit = 1'b0;
   logic align_en = 1'b0;
   logic          char_vld, half_sel, comma_flag;
   logic [CW-1:0] char_data;

   int checks = 0;
   int errors = 0;
   int bitidx = 0;
   logic prev_vld = 1'b0;

   int         n_exp = 0;
   int         exp_p [16];
   logic [9:0] exp_d [16];
   logic       exp_h [16];
   string      exp_t [16];
   bit         cad_on = 1'b0;
   int         cad_base = 9;

   logic [15:0] lf = 16'hACE1;
   logic        lastb = 1'b0;
   int          run = 0;

   always #4 clk = ~clk;

   serial_word_aligner dut_i (
      .clk(clk), .rst(rst), .ser_bit(ser_bit), .align_en(align_en),
      .char_vld(char_vld), .char_data(char_data),
      .half_sel(half_sel), .comma_flag(comma_flag)
   );

   task automatic chk(input bit ok, input string tag, input string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: got vld=%0b flag=%0b half=%0b data=%h", tag, what,
                  char_vld, comma_flag, half_sel, char_data);
      end
   endtask

   task automatic check_resp(input int p);
      bit found = 1'b0;
      for (int i = 0; i < n_exp; i++) begin
         if (exp_p[i] == p) begin
            found = 1'b1;
            chk(char_vld && (comma_flag == (exp_t[i] != "R9")) &&
                char_data == exp_d[i] && half_sel == exp_h[i], exp_t[i],
                $sformatf("bit %0d, expected vld=1 flag=%0b half=%0b data=%h",
                          p, exp_t[i] != "R9", exp_h[i], exp_d[i]));
         end
      end
      if (!found) chk(!comma_flag, "R8", $sformatf("bit %0d, expected flag=0", p));
      if (cad_on && p >= cad_base - CW)
         chk(char_vld == (((p - cad_base) % CW) == 0), "R2",
             $sformatf("bit %0d, expected vld=%0b", p, ((p - cad_base) % CW) == 0));
      chk(!(char_vld && prev_vld), "R11", "expected no back-to-back strobe");
      prev_vld = char_vld;
   endtask

   task automatic step(input logic b);
      @(negedge clk);
      if (bitidx > 0) check_resp(bitidx - 1);
      rst = 1'b0;
      ser_bit = b;
      bitidx++;
   endtask

   task automatic gen_bit(output logic b);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      b = lf[0];
      if (run >= 2 && b == lastb) b = ~lastb;
      if (b == lastb) run++;
      else run = 1;
      lastb = b;
   endtask

   task automatic send_gen(input int n);
      logic b;
      for (int i = 0; i < n; i++) begin
         gen_bit(b);
         step(b);
      end
   endtask

   task automatic gen_word(output logic [9:0] w);
      for (int i = 0; i < CW; i++) gen_bit(w[i]);
   endtask

   // R3: bit 0 goes out first
   task automatic send_word(input logic [9:0] w);
      for (int i = 0; i < CW; i++) step(w[i]);
   endtask

   task automatic expect_at(input int p, input logic [9:0] d, input logic h, input string t);
      exp_p[n_exp] = p;
      exp_d[n_exp] = d;
      exp_h[n_exp] = h;
      exp_t[n_exp] = t;
      n_exp++;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk(!char_vld && !comma_flag && !half_sel, "R1", "expected all outputs low");
      bitidx = 0;
      n_exp = 0;
      prev_vld = 1'b0;
      cad_on = 1'b0;
      cad_base = 9;
   endtask

   initial begin
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL R10 watchdog expired: got no finish, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [9:0] w, km;
      int lead, ce;
      bit en, sched;
      logic hk;
      string tg;

      for (int v = 0; v < NV; v++) begin
         en   = VECS[v][7];
         km   = VECS[v][6] ? K_POS : K_NEG;
         lead = int'(VECS[v][5:0]);
         do_reset();
         align_en = en;
         cad_on = !en;
         ce = lead + 9;
         sched = en || (lead % CW == 0);
         hk = en ? 1'b1 : logic'((lead / CW) % 2);
         if (!en) tg = "R8";
         else if (lead % CW != 0) tg = "R5";
         else if ((lead / CW) % 2 == 1) tg = "R7";
         else tg = "R6";
         send_gen(lead);
         if (sched) expect_at(ce, km, hk, tg);   // R10: due after its tenth bit
         send_word(km);
         for (int k = 1; k <= 4; k++) begin
            gen_word(w);
            if (sched) expect_at(ce + CW * k, w, hk ^ logic'(k % 2), "R9");
            send_word(w);
         end
         send_gen(3);
      end

      // R7: two marks in a row, the second already framed in slot two
      do_reset();
      align_en = 1'b1;
      send_gen(3);
      expect_at(12, K_NEG, 1'b1, "R5");
      send_word(K_NEG);
      gen_word(w);
      expect_at(22, w, 1'b0, "R9");
      send_word(w);
      expect_at(32, K_POS, 1'b1, "R7");
      send_word(K_POS);
      gen_word(w);
      expect_at(42, w, 1'b0, "R9");
      send_word(w);
      send_gen(3);

      // R2: enable dropped after alignment, a later off-boundary mark is ignored
      do_reset();
      align_en = 1'b1;
      send_gen(5);
      expect_at(14, K_NEG, 1'b1, "R5");
      send_word(K_NEG);
      align_en = 1'b0;
      cad_on = 1'b1;
      cad_base = 14;
      gen_word(w);
      expect_at(24, w, 1'b0, "R9");
      send_word(w);
      send_gen(4);
      send_word(K_POS);
      send_gen(25);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule